// File: doc/BRIEF.md
# Multi-Source Interrupt Status Aggregator

The aggregator watches 24 event inputs and records each one in a sticky status bit. The status bits are grouped into three byte-wide banks. Each bank has two mask bytes. The capture mask decides whether a rising edge on a source is recorded at all. The line mask decides whether a recorded bit contributes to the single active-high interrupt request.

Software reaches all nine bytes over a simple byte-wide register bus with a write strobe and a combinational read port. The three status bytes sit at consecutive addresses, so an incrementing burst read returns the 24 bits in order. Status is never cleared bit by bit. A single byte write to any of the three status addresses clears every status bit, whatever data is written. Mask bits are plain read/write storage, so drivers change them with read-modify-write.

Top module: `irq_agg`

## Requirements
- R1: After reset every mask byte reads 0xFF, every status byte reads 0x00 and `irq_o` is 0.
- R2: A 0-to-1 transition on `src_i[n]` whose capture mask bit is 0 sets status bit n on that clock edge. Bit n is held in bank n/8 at bit n%8, with bank A for bits 0-7, bank B for bits 8-15 and bank C for bits 16-23. A source held high does not set the bit again after a clear.
- R3: A transition on a source whose capture mask bit is 1 leaves its status bit unchanged.
- R4: A set status bit stays set until a clear-all write.
- R5: A write to address 0, 1 or 2 with any data clears all 24 status bits on that edge.
- R6: When an enabled rising edge and a clear-all write fall on the same edge, the bit of the new event is set after that edge, and all other status bits are cleared.
- R7: `irq_o` is 1 exactly while some status bit is 1 and its line mask bit is 0. It follows changes to the masks in the cycle after the write.
- R8: Status bits 12 and 23 are reserved. They always read 0, even when their sources toggle with capture enabled.
- R9: The address map is status A/B/C at 0-2, line masks A/B/C at 3-5 and capture masks A/B/C at 6-8. A mask write stores all 8 data bits and reads back unchanged. Reads of addresses 9-15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 24 | Event source levels |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address for both read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request, active high level |

## Verification
Single pulses on one bit in each bank check the bit placement, and the line mask is opened one bank at a time to show that the request depends on both a set bit and an open line. A source held high across a clear separates edge capture from level capture. A capture mask that enables only one of two pulsed neighbours shows that masking works per bit. A clear write timed on the same edge as a fresh event shows that the event takes priority. Pulses on the reserved positions, reads of unused addresses and a mask read-modify-write complete the register map checks.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  parameter int unsigned BANK_W    = 8;
  parameter int unsigned NUM_BANKS = 3;
  parameter int unsigned SRC_W     = BANK_W * NUM_BANKS;
  parameter int unsigned ADDR_W    = 4;
  // base addresses of the three register groups
  parameter int unsigned STS_BASE  = 0;
  parameter int unsigned LINE_BASE = STS_BASE + NUM_BANKS;
  parameter int unsigned CAP_BASE  = LINE_BASE + NUM_BANKS;
  // positions that never record
  parameter logic [SRC_W-1:0] RSVD_BITS = SRC_W'(24'h80_1000);
endpackage

// File: rtl/irq_agg_bank.sv
module irq_agg_bank #(
  parameter int unsigned       W    = 8,
  parameter logic [W-1:0]      RSVD = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         clr_i,
  input  logic         line_we_i,
  input  logic         cap_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] line_mask_o,
  output logic [W-1:0] cap_mask_o,
  output logic         req_o
);
  logic [W-1:0] src_q, status_q, line_q, cap_q;
  logic [W-1:0] rise, capture;

  assign rise    = src_i & ~src_q;
  assign capture = rise & ~cap_q & ~RSVD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= '0;
      status_q <= '0;
      line_q   <= '1;
      cap_q    <= '1;
    end else begin
      src_q    <= src_i;
      // new event wins over the clear
      status_q <= (clr_i ? '0 : status_q) | capture;
      if (line_we_i) line_q <= wdata_i;
      if (cap_we_i)  cap_q  <= wdata_i;
    end
  end

  assign status_o    = status_q;
  assign line_mask_o = line_q;
  assign cap_mask_o  = cap_q;
  assign req_o       = |(status_q & ~line_q);

  // R4
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R3
  masked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && ((src_i & ~src_q & ~cap_q) == '0)) |=> (status_q == $past(status_q)));
  // R5
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && ((src_i & ~src_q) == '0)) |=> (status_q == '0));
  // R6
  event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && ((src_i & ~src_q & ~cap_q & ~RSVD) != '0)) |=> (status_q != '0));
  // R8
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & RSVD) == '0));
endmodule

// File: rtl/irq_agg_regif.sv
module irq_agg_regif #(
  parameter int unsigned W      = 8,
  parameter int unsigned NB     = 3,
  parameter int unsigned AW     = 4,
  parameter int unsigned STS_A  = 0,
  parameter int unsigned LINE_A = 3,
  parameter int unsigned CAP_A  = 6
) (
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [NB-1:0][W-1:0] status_i,
  input  logic [NB-1:0][W-1:0] line_i,
  input  logic [NB-1:0][W-1:0] cap_i,
  output logic                 clr_o,
  output logic [NB-1:0]        line_we_o,
  output logic [NB-1:0]        cap_we_o,
  output logic [W-1:0]         rdata_o
);
  logic [NB-1:0] hit_sts, hit_line, hit_cap;

  for (genvar b = 0; b < NB; b++) begin : g_dec
    assign hit_sts[b]   = (addr_i == AW'(STS_A + b));
    assign hit_line[b]  = (addr_i == AW'(LINE_A + b));
    assign hit_cap[b]   = (addr_i == AW'(CAP_A + b));
    assign line_we_o[b] = wr_en_i & hit_line[b];
    assign cap_we_o[b]  = wr_en_i & hit_cap[b];
  end

  assign clr_o = wr_en_i & (|hit_sts);

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NB; b++) begin
      if (hit_sts[b])  rdata_o = status_i[b];
      if (hit_line[b]) rdata_o = line_i[b];
      if (hit_cap[b])  rdata_o = cap_i[b];
    end
  end
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_W-1:0]  src_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [NUM_BANKS-1:0][BANK_W-1:0] status, line_mask, cap_mask;
  logic [NUM_BANKS-1:0]             line_we, cap_we, req;
  logic                             clr;

  irq_agg_regif #(
    .W(BANK_W), .NB(NUM_BANKS), .AW(ADDR_W),
    .STS_A(STS_BASE), .LINE_A(LINE_BASE), .CAP_A(CAP_BASE)
  ) u_regif (
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .status_i (status),
    .line_i   (line_mask),
    .cap_i    (cap_mask),
    .clr_o    (clr),
    .line_we_o(line_we),
    .cap_we_o (cap_we),
    .rdata_o  (rdata_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irq_agg_bank #(
      .W(BANK_W), .RSVD(RSVD_BITS[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_i[b*BANK_W +: BANK_W]),
      .clr_i      (clr),
      .line_we_i  (line_we[b]),
      .cap_we_i   (cap_we[b]),
      .wdata_i    (wdata_i),
      .status_o   (status[b]),
      .line_mask_o(line_mask[b]),
      .cap_mask_o (cap_mask[b]),
      .req_o      (req[b])
    );
  end

  assign irq_o = |req;

  // R7
  irq_needs_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status != '0));
  // R1
  masks_closed_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&line_mask) |-> !irq_o);
  // R5
  single_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({clr, |line_we, |cap_we}));
endmodule

// File: tb/irq_agg_test.sv
module irq_agg_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [23:0] src = '0;
  logic        wr_en = 0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  irq_agg uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(int bitn);
    @(negedge clk);
    src[bitn] = 1;
    @(negedge clk);
    src[bitn] = 0;
  endtask

  task automatic check_sts(string req, logic [7:0] a, logic [7:0] b, logic [7:0] c);
    logic [7:0] d;
    rd(0, d); check(req, d, a);
    rd(1, d); check(req, d, b);
    rd(2, d); check(req, d, c);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 3; a < 9; a++) begin
      rd(4'(a), d); check("R1", d, 8'hFF);
    end
    check_sts("R1", 0, 0, 0);
    check("R1", {7'd0, irq}, 0);
  endtask

  task automatic t_capture_and_line;
    wr(6, 0); wr(7, 0); wr(8, 0);
    pulse(0); pulse(9); pulse(17);
    check_sts("R2", 8'h01, 8'h02, 8'h02);
    check("R7", {7'd0, irq}, 0);
    wr(4, 8'hFD);
    check("R7", {7'd0, irq}, 1);
    wr(4, 8'h02);
    check("R7", {7'd0, irq}, 0);
    wr(3, 8'hFE);
    check("R7", {7'd0, irq}, 1);
    repeat (5) @(negedge clk);
    check_sts("R4", 8'h01, 8'h02, 8'h02);
  endtask

  task automatic t_clear;
    wr(1, 8'hFF);
    check_sts("R5", 0, 0, 0);
    check("R7", {7'd0, irq}, 0);
  endtask

  task automatic t_masked;
    wr(6, 8'hFE);
    pulse(1);
    check_sts("R3", 0, 0, 0);
    pulse(0);
    check_sts("R3", 8'h01, 0, 0);
    wr(0, 8'h00);
    wr(6, 8'h00);
  endtask

  task automatic t_edge_only;
    @(negedge clk); src[5] = 1;
    @(negedge clk);
    check_sts("R2", 8'h20, 0, 0);
    wr(2, 8'h5A);
    repeat (4) @(negedge clk);
    check_sts("R2", 0, 0, 0);
    src[5] = 0;
  endtask

  task automatic t_reserved;
    pulse(12); pulse(23);
    check_sts("R8", 0, 0, 0);
  endtask

  task automatic t_collision;
    pulse(3);
    check_sts("R6", 8'h08, 0, 0);
    @(negedge clk);
    addr = 2; wdata = 8'h00; wr_en = 1; src[20] = 1;
    @(negedge clk);
    wr_en = 0; src[20] = 0;
    check_sts("R6", 0, 0, 8'h10);
    wr(0, 0);
  endtask

  task automatic t_map;
    logic [7:0] d;
    rd(9, d);  check("R9", d, 0);
    rd(15, d); check("R9", d, 0);
    rd(5, d);  check("R9", d, 8'hFF);
    wr(5, d & ~8'h04);
    rd(5, d);  check("R9", d, 8'hFB);
    wr(8, 8'hA5);
    rd(8, d);  check("R9", d, 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_capture_and_line();
    t_clear();
    t_masked();
    t_edge_only();
    t_reserved();
    t_collision();
    t_map();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule